// File: doc/BRIEF.md
# Two-Channel Burst Acquisition Scheduler

This block sets the order and timing of the acquisition bursts for a two-channel capacitive sensor. Every acquisition cycle has one burst for channel 2 and then one burst for channel 1. Each burst is requested from an external measurement front end with a one-cycle start pulse and finishes when the front end returns a done strobe. The block reports the end of each burst downstream and produces one timebase tick per cycle. That tick is tagged with whether the no-sleep setting is in force, so that the downstream drift and timeout counters can pick their scaling.

Between cycles the block can sleep until a programmed number of basic-interval ticks has passed since the current cycle began. This places channel 2 burst starts on a fixed grid. With a count of zero the cycles run back to back. A global fast-integration enable cuts the sleep short whenever either channel reports a pending detection. Every cycle except the first one after reset opens with a heartbeat window of fixed length, during which both sensor outputs are released. The channel 2 request follows the heartbeat directly.

Top module: `burst_sched`

## Requirements
- R1: While rst_ni is low, every output is 0. On the first clock edge after release, burst_start_o and burst_ch2_o go high together, and no heartbeat comes before this first request.
- R2: burst_start_o is a one-cycle pulse. Requests alternate channel 2, channel 1, channel 2, and so on. A new request is issued only after the done strobe for the previous burst.
- R3: burst_ch2_o encodes the channel: 1 means channel 2 and 0 means channel 1. It holds its value from the request until that burst's done strobe is taken.
- R4: The cycle after burst_done_i is taken during a channel's burst, done_ch2_o or done_ch1_o pulses for exactly one cycle. A burst_done_i that arrives while no burst is in flight has no effect.
- R5: hb_o is high for exactly HB_CYCLES consecutive cycles. No request is issued during that window, and the channel 2 request is issued in the cycle right after it ends.
- R6: With sleep_cycles_i greater than 0, the heartbeat that opens the next cycle starts on the clock after the point where both of these are true: the channel 1 burst is done, and sleep_cycles_i ticks of ti_tick_i have been counted since the current heartbeat started. A tick that falls on the edge that opens a heartbeat is not counted.
- R7: With sleep_cycles_i equal to 0, the next heartbeat starts on the clock right after the channel 1 done strobe is taken.
- R8: If the required ticks have already been counted when channel 1 finishes, no sleep is inserted and the next heartbeat starts on the following clock.
- R9: When fast_int_i is 1 and any bit of pend_i is 1, the sleep is skipped or ended on the next clock. When fast_int_i is 0, pend_i has no effect.
- R10: tb_tick_o pulses once per cycle, together with done_ch1_o. tb_nosleep_o is 1 only in that pulse, and only when sleep_cycles_i was 0 at the time the channel 1 done strobe was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ti_tick_i | input | 1 | One-cycle tick per basic timing interval |
| sleep_cycles_i | input | SC_W | Number of basic intervals between cycle starts; 0 means no sleep |
| fast_int_i | input | 1 | Global enable for skipping the sleep while a detection is pending |
| pend_i | input | 2 | Detection pending per channel (bit 1 = channel 2, bit 0 = channel 1) |
| burst_done_i | input | 1 | End-of-burst strobe from the front end |
| burst_start_o | output | 1 | One-cycle burst request |
| burst_ch2_o | output | 1 | Channel of the current burst (1 = channel 2) |
| hb_o | output | 1 | Heartbeat window; both outputs released while high |
| done_ch1_o | output | 1 | Channel 1 burst finished |
| done_ch2_o | output | 1 | Channel 2 burst finished |
| tb_tick_o | output | 1 | Timebase tick, one per acquisition cycle |
| tb_nosleep_o | output | 1 | Tag on the tick: this cycle ran with no sleep |

## Verification
The bound checker checks several rules on every cycle. Requests are single-cycle pulses. No request is issued inside a heartbeat, and every heartbeat ends in a channel 2 request. A channel 1 request is issued only in the cycle right after the channel 2 done strobe. The channel select never rises without a request. A tick tagged no-sleep always coincides with the start of a heartbeat. The exact clock on which a heartbeat opens depends on ticks counted across a whole cycle, on the pending inputs, and on overrun, so only the bench's scenarios can show it. Those scenarios cover a sleeping grid, zero spacing, overrun, fast mode with and without its enable, and stray done strobes, and the bench models the tick count on its own.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HB,
    ST_REQ2,
    ST_WAIT2,
    ST_REQ1,
    ST_WAIT1,
    ST_SLEEP
  } sched_state_e;
endpackage

// File: rtl/sched_hb_timer.sv
module sched_hb_timer #(
  parameter int unsigned HB_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic last_o
);
  localparam int unsigned CW = (HB_CYCLES > 1) ? $clog2(HB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HB_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (!last_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = active_i && (cnt_q == LAST);
endmodule

// File: rtl/sched_ti_spacer.sv
module sched_ti_spacer #(
  parameter int unsigned SC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            clear_i,
  input  logic [SC_W-1:0] sc_i,
  output logic            reached_o
);
  logic [SC_W-1:0] cnt_q;

  // saturating count of basic intervals since the current cycle began
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= '0;
    else if (tick_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q >= sc_i);
endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int unsigned SC_W      = 8,
  parameter int unsigned HB_CYCLES = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ti_tick_i,
  input  logic [SC_W-1:0] sleep_cycles_i,
  input  logic            fast_int_i,
  input  logic [1:0]      pend_i,
  input  logic            burst_done_i,
  output logic            burst_start_o,
  output logic            burst_ch2_o,
  output logic            hb_o,
  output logic            done_ch1_o,
  output logic            done_ch2_o,
  output logic            tb_tick_o,
  output logic            tb_nosleep_o
);
  sched_state_e state_q, state_d;
  logic sc_zero, reached, go_now, hb_last, enter_hb;
  logic done1_q, done2_q, nosleep_q;

  assign sc_zero = (sleep_cycles_i == '0);
  assign go_now  = sc_zero || (fast_int_i && (|pend_i)) || reached;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_REQ2;
      ST_HB:    if (hb_last) state_d = ST_REQ2;
      ST_REQ2:  state_d = ST_WAIT2;
      ST_WAIT2: if (burst_done_i) state_d = ST_REQ1;
      ST_REQ1:  state_d = ST_WAIT1;
      ST_WAIT1: if (burst_done_i) state_d = go_now ? ST_HB : ST_SLEEP;
      ST_SLEEP: if (go_now) state_d = ST_HB;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign enter_hb = (state_d == ST_HB) && (state_q != ST_HB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done1_q   <= 1'b0;
      done2_q   <= 1'b0;
      nosleep_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      done2_q   <= (state_q == ST_WAIT2) && burst_done_i;
      done1_q   <= (state_q == ST_WAIT1) && burst_done_i;
      nosleep_q <= (state_q == ST_WAIT1) && burst_done_i && sc_zero;
    end
  end

  sched_hb_timer #(.HB_CYCLES(HB_CYCLES)) u_hb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(state_q == ST_HB),
    .last_o  (hb_last)
  );

  sched_ti_spacer #(.SC_W(SC_W)) u_space (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (ti_tick_i),
    .clear_i  (enter_hb),
    .sc_i     (sleep_cycles_i),
    .reached_o(reached)
  );

  assign burst_start_o = (state_q == ST_REQ2) || (state_q == ST_REQ1);
  assign burst_ch2_o   = (state_q == ST_REQ2) || (state_q == ST_WAIT2);
  assign hb_o          = (state_q == ST_HB);
  assign done_ch1_o    = done1_q;
  assign done_ch2_o    = done2_q;
  assign tb_tick_o     = done1_q;
  assign tb_nosleep_o  = nosleep_q;
endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic burst_start_o,
  input logic burst_ch2_o,
  input logic hb_o,
  input logic done_ch1_o,
  input logic done_ch2_o,
  input logic tb_nosleep_o
);
  a_r2_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_o |=> !burst_start_o);

  a_r2_ch1_after_ch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_start_o && !burst_ch2_o) |-> done_ch2_o);

  a_r3_ch_select_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_ch2_o && !burst_start_o) |-> $past(burst_ch2_o));

  a_r4_done_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_ch1_o && done_ch2_o));

  a_r5_no_req_in_hb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_o |-> !burst_start_o);

  a_r5_hb_then_ch2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hb_o) |-> (burst_start_o && burst_ch2_o));

  a_r7_nosleep_hb_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_nosleep_o |-> hb_o);
endmodule

bind burst_sched burst_sched_chk u_burst_sched_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .burst_start_o(burst_start_o),
  .burst_ch2_o  (burst_ch2_o),
  .hb_o         (hb_o),
  .done_ch1_o   (done_ch1_o),
  .done_ch2_o   (done_ch2_o),
  .tb_nosleep_o (tb_nosleep_o)
);

// File: tb/burst_sched_bench.sv
`timescale 1ns/1ps
module burst_sched_bench;
  localparam int HB = 3;
  localparam int TI_PER = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ti_tick_i = 1'b0;
  logic [7:0] sleep_cycles_i = '0;
  logic fast_int_i = 1'b0;
  logic [1:0] pend_i = '0;
  logic burst_done_i = 1'b0;
  logic burst_start_o, burst_ch2_o, hb_o, done_ch1_o, done_ch2_o, tb_tick_o, tb_nosleep_o;

  always #2.5 clk = ~clk;

  burst_sched #(.SC_W(8), .HB_CYCLES(HB)) u_burst_sched (
    .clk_i(clk), .rst_ni(rst_ni), .ti_tick_i(ti_tick_i), .sleep_cycles_i(sleep_cycles_i),
    .fast_int_i(fast_int_i), .pend_i(pend_i), .burst_done_i(burst_done_i),
    .burst_start_o(burst_start_o), .burst_ch2_o(burst_ch2_o), .hb_o(hb_o),
    .done_ch1_o(done_ch1_o), .done_ch2_o(done_ch2_o), .tb_tick_o(tb_tick_o),
    .tb_nosleep_o(tb_nosleep_o)
  );

  int n_run = 0, n_fail = 0;
  int q[$];
  int cfg_sc = 3, cfg_bl = 4;
  bit cfg_fast = 0, cfg_spur = 0;
  logic [1:0] cfg_pend = '0;
  bit live = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic run_phase(int sc, int bl, bit fast, logic [1:0] pend, bit spur, int n);
    cfg_sc = sc; cfg_bl = bl; cfg_fast = fast; cfg_pend = pend; cfg_spur = spur;
    for (int i = 0; i < n; i++) begin
      q.push_back(2);
      q.push_back(1);
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor and front-end model: all DUT inputs are driven here at negedge
  initial begin
    int cyc = 0, bt = 0, hbw = 0, bl_cnt = 0, cur_ch = 0, done_ch = 0, last_ch = 1, exp_ch;
    bit waiting = 0, exp_valid = 0, exp_hb = 0, hb_prev = 0, outst = 0;
    bit done_pend = 0, done_ns = 0, tick_drv = 0, just_done, hb_rise;
    string tag = "R6";
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
      if (live) begin
        hb_rise = hb_o && !hb_prev;
        if (hb_rise) chk(exp_valid && exp_hb, tag, 1, 0);
        else if (exp_valid) chk(!exp_hb, tag, 0, 1);
        if (hb_o) hbw++;
        else if (hb_prev) begin
          chk(hbw == HB, "R5 hb width", hbw, HB);
          chk(burst_start_o && burst_ch2_o, "R5 ch2 after hb", burst_start_o, 1);
          hbw = 0;
        end
        if (burst_start_o) begin
          exp_ch = (q.size() != 0) ? q.pop_front() : ((last_ch == 2) ? 1 : 2);
          chk(burst_ch2_o == (exp_ch == 2), "R2 order", burst_ch2_o, exp_ch == 2);
          chk(!outst, "R2 overlap", outst, 0);
          last_ch = exp_ch;
        end else if (outst) begin
          chk(burst_ch2_o == (cur_ch == 2), "R3 ch held", burst_ch2_o, cur_ch == 2);
        end
        chk(done_ch2_o == (done_pend && done_ch == 2), "R4 done ch2", done_ch2_o, done_pend && done_ch == 2);
        chk(done_ch1_o == (done_pend && done_ch == 1), "R4 done ch1", done_ch1_o, done_pend && done_ch == 1);
        chk(tb_tick_o == (done_pend && done_ch == 1), "R10 tick", tb_tick_o, done_pend && done_ch == 1);
        chk(tb_nosleep_o == (done_pend && done_ch == 1 && done_ns), "R10 nosleep", tb_nosleep_o,
            done_pend && done_ch == 1 && done_ns);
        done_pend = 0;
        if (hb_rise) begin bt = 0; waiting = 0; end
        else if (tick_drv && bt < 255) bt++;
        hb_prev = hb_o;

        tick_drv = (cyc % TI_PER == 0);
        ti_tick_i = tick_drv;
        sleep_cycles_i = 8'(cfg_sc);
        fast_int_i = cfg_fast;
        pend_i = cfg_pend;
        burst_done_i = 1'b0;
        just_done = 0;
        if (burst_start_o) begin
          outst = 1; bl_cnt = cfg_bl; cur_ch = burst_ch2_o ? 2 : 1;
        end
        if (outst) begin
          bl_cnt--;
          if (bl_cnt == 0) begin
            burst_done_i = 1'b1; outst = 0; done_pend = 1; done_ch = cur_ch;
            done_ns = (cfg_sc == 0);
            if (cur_ch == 1) begin waiting = 1; just_done = 1; end
          end
        end else if (cfg_spur && (cyc % 3 == 0)) begin
          burst_done_i = 1'b1; // stray strobe, must be ignored (R4)
        end

        if (waiting) begin
          exp_valid = 1;
          if (cfg_sc == 0) begin exp_hb = 1; tag = "R7 no-sleep hb"; end
          else if (cfg_fast && (|cfg_pend)) begin exp_hb = 1; tag = "R9 fast skip"; end
          else if (bt >= cfg_sc) begin exp_hb = 1; tag = just_done ? "R8 overrun" : "R6 grid"; end
          else begin exp_hb = 0; tag = (|cfg_pend) ? "R9 pend ignored" : "R6 sleep"; end
        end else begin
          exp_valid = 0;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!burst_start_o && !burst_ch2_o && !hb_o && !done_ch1_o && !done_ch2_o
          && !tb_tick_o && !tb_nosleep_o, "R1 reset outputs", burst_start_o, 0);
    end
    q.push_back(2); q.push_back(1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    live = 1;
    #1;
    chk(burst_start_o && burst_ch2_o && !hb_o, "R1 first ch2 request", burst_start_o, 1);
    while (q.size() != 0) @(negedge clk);
    run_phase(3, 4, 0, 2'b00, 0, 3);   // R6 sleeping grid
    run_phase(0, 3, 0, 2'b00, 0, 3);   // R7, R10 no sleep
    run_phase(1, 12, 0, 2'b00, 0, 3);  // R8 overrun
    run_phase(4, 3, 1, 2'b01, 0, 3);   // R9 fast skip
    run_phase(4, 3, 1, 2'b10, 0, 2);   // R9 other channel pending
    run_phase(4, 3, 0, 2'b11, 0, 2);   // R9 pend ignored without enable
    run_phase(2, 5, 0, 2'b00, 1, 3);   // R4 stray done strobes
    run_phase(6, 2, 0, 2'b00, 0, 2);   // R6 longer grid
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule